// File: doc/BRIEF.md
# Translated Byte-Access Data Cache

This block is the data-side memory front end of a byte-addressable 32-bit processor. It takes one byte load or byte store at a time, addressed by a 32-bit virtual address. Two lookups start together from the latched request. The first is a small two-way translation buffer that maps the virtual page to a physical page. The second is a read of a two-way data cache set. The set is chosen with address bits that lie inside the 16 KB page offset, so this read does not wait for translation. The physical page number is then compared against the stored physical tags of that set.

A hit returns the addressed byte, zero-extended to 32 bits, or merges the store byte into the line. A miss picks the least recently used way of the set as the victim. If that line is dirty it is written back first, and then the new block is fetched over a line-wide memory port. After the fill the lookup repeats and hits. A missing translation produces a miss response at once, with no cache or memory activity. Translations are loaded by an external agent through a plain write port.

Requests and responses use valid/ready handshakes. `req_ready` is high only while the block is idle, so at most one request is in flight. The response is held with its data stable until `rsp_ready` is seen. The memory request port holds valid, address, direction and data stable until `mem_req_ready`. Read data comes back later as a single `mem_rsp_valid` beat, which the block always accepts.

Top module: `vipt_byte_cache`

## Requirements
- R1: Coming out of reset, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0. All translation and cache entries are invalid.
- R2: A request whose virtual page number (VA[31:14]) matches no valid translation entry gives a response with `rsp_tlb_miss`=1 and `rsp_rdata`=0. It issues no memory request and changes no cache line.
- R3: A translation write with page number V and frame P goes to set V[1:0] with tag V[17:2]. It overwrites the way that already holds that tag, and otherwise the least recently used way of that set. No set ever holds two valid entries with the same tag.
- R4: The physical address is {PPN, VA[13:0]}, 26 bits. The cache set is VA[5:3], and the line tag is {PPN, VA[13:6]}. Memory block addresses are PA[25:3].
- R5: A load returns the byte at block offset VA[2:0] in `rsp_rdata[7:0]`, with bits [31:8] zero. Offset 0 is line bits [63:56] and offset 7 is line bits [7:0]. For example, block 0x0123456789ABCDEF at offset 6 gives 0xCD.
- R6: A load miss to a clean or empty victim issues exactly one memory read, for the block address of the request. A later access to the same block hits with no memory traffic.
- R7: A store writes its byte into the line, marks the line dirty and responds with `rsp_rdata`=0. A store miss first fetches the block, then merges the byte (write-allocate). A load of that byte afterwards returns the stored value.
- R8: When the victim is valid and dirty, it is written to memory at its own block address with its current data. This write is accepted before the read of the new block is issued.
- R9: Each cache set keeps one recency bit, and the victim is always the way not used by the most recent hit in that set.
- R10: `req_ready` is 0 from the cycle after a request is accepted until its response is taken. `rsp_valid`, `rsp_rdata` and `rsp_tlb_miss` hold stable while `rsp_ready` is 0. `mem_req_valid` and the request fields hold stable while `mem_req_ready` is 0.
- R11: Two virtual pages translated to the same physical page share cache lines. A byte stored through one page is read back through the other with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_write | input | 1 | 1 = byte store, 0 = byte load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Zero-extended load byte, 0 for stores and translation misses |
| rsp_tlb_miss | output | 1 | No translation for the request page |
| tlb_wr_en | input | 1 | Write one translation entry |
| tlb_wr_vpn | input | 18 | Virtual page number to install |
| tlb_wr_ppn | input | 12 | Physical page number to install |
| mem_req_valid | output | 1 | Memory block request offered |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_write | output | 1 | 1 = write back, 0 = block read |
| mem_req_addr | output | 23 | Physical block address |
| mem_req_wdata | output | 64 | Write-back line |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 64 | Read block |

## Verification
The hold properties on the memory port and the response port assume the environment keeps its side of each handshake. `mem_rsp_valid` must pulse only once for each accepted read, and translation writes must arrive only while `req_ready` is high, so the physical tag cannot change under a miss. The stimulus meets these assumptions: its memory model answers each accepted read with one beat a cycle later, and it writes translations only between requests. It still stalls `mem_req_ready` and `rsp_ready` in a repeating pattern, so the hold rules are exercised under back-pressure.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FREQ,
    ST_FWAIT,
    ST_RESP
  } vbc_state_t;
endpackage

// File: rtl/vbc_tlb.sv
module vbc_tlb #(
  parameter int SETS  = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 12,
  localparam int IW    = $clog2(SETS),
  localparam int VPN_W = TAG_W + IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_touch,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);
  logic             vld [2][SETS];
  logic [TAG_W-1:0] tg  [2][SETS];
  logic [PPN_W-1:0] pp  [2][SETS];
  logic             lru [SETS];

  logic [IW-1:0]    lset, wset;
  logic [TAG_W-1:0] ltag, wtag;
  logic [1:0]       hv, wm;
  logic             wway;

  assign lset = lk_vpn[IW-1:0];
  assign ltag = lk_vpn[VPN_W-1:IW];
  assign wset = wr_vpn[IW-1:0];
  assign wtag = wr_vpn[VPN_W-1:IW];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hv[w] = vld[w][lset] && (tg[w][lset] == ltag);
    assign wm[w] = vld[w][wset] && (tg[w][wset] == wtag);
  end

  assign lk_hit = |hv;
  assign lk_ppn = hv[1] ? pp[1][lset] : pp[0][lset];
  // Matching way first, so a page never occupies two ways.
  assign wway   = wm[1] ? 1'b1 : (wm[0] ? 1'b0 : lru[wset]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[0][s] <= 1'b0;
        vld[1][s] <= 1'b0;
        lru[s]    <= 1'b0;
      end
    end else if (wr_en) begin
      vld[wway][wset] <= 1'b1;
      tg[wway][wset]  <= wtag;
      pp[wway][wset]  <= wr_ppn;
      lru[wset]       <= ~wway;
    end else if (lk_touch && lk_hit) begin
      lru[lset] <= ~hv[1];
    end
  end

  // R3
  tlb_single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv));
endmodule

// File: rtl/vbc_cache_array.sv
module vbc_cache_array #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 64,
  localparam int IW    = $clog2(SETS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IW-1:0]          idx,
  output logic [1:0]             o_vld,
  output logic [1:0]             o_dty,
  output logic [1:0][TAG_W-1:0]  o_tag,
  output logic [1:0][LINE_W-1:0] o_data,
  output logic                   o_lru,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic [LINE_W-1:0]      wr_data,
  input  logic                   wr_dirty,
  input  logic                   touch_en,
  input  logic                   touch_way
);
  logic [1:0]        vld [SETS];
  logic [1:0]        dty [SETS];
  logic [TAG_W-1:0]  tg  [2][SETS];
  logic [LINE_W-1:0] dat [2][SETS];
  logic              lru [SETS];

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign o_tag[w]  = tg[w][idx];
    assign o_data[w] = dat[w][idx];
  end
  assign o_vld = vld[idx];
  assign o_dty = dty[idx];
  assign o_lru = lru[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        dty[s] <= '0;
        lru[s] <= 1'b0;
      end
    end else begin
      if (wr_en) begin
        vld[idx][wr_way] <= 1'b1;
        dty[idx][wr_way] <= wr_dirty;
        tg[wr_way][idx]  <= wr_tag;
        dat[wr_way][idx] <= wr_data;
      end
      if (touch_en) lru[idx] <= ~touch_way;
    end
  end
endmodule

// File: rtl/vbc_lane.sv
module vbc_lane #(
  parameter int LINE_BYTES = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic [LINE_W-1:0] line_in,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        wbyte,
  output logic [7:0]        rbyte,
  output logic [LINE_W-1:0] merged
);
  // Offset 0 occupies the most significant byte of the line.
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign merged[LINE_W-1-8*b -: 8] =
      (off == OFF_W'(b)) ? wbyte : line_in[LINE_W-1-8*b -: 8];
  end

  always_comb begin
    rbyte = '0;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (off == OFF_W'(b)) rbyte = line_in[LINE_W-1-8*b -: 8];
    end
  end
endmodule

// File: rtl/vipt_byte_cache.sv
module vipt_byte_cache
  import vbc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 26,
  parameter int PAGE_W     = 14,
  parameter int DATA_W     = 32,
  parameter int TLB_SETS   = 4,
  parameter int C_SETS     = 8,
  parameter int LINE_BYTES = 8,
  localparam int VPN_W     = VA_W - PAGE_W,
  localparam int PPN_W     = PA_W - PAGE_W,
  localparam int TLB_IW    = $clog2(TLB_SETS),
  localparam int TLB_TAG_W = VPN_W - TLB_IW,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(C_SETS),
  localparam int LINE_W    = 8 * LINE_BYTES,
  localparam int CTAG_W    = PA_W - OFF_W - IDX_W,
  localparam int BLK_W     = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_tlb_miss,
  input  logic              tlb_wr_en,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic [PPN_W-1:0]  tlb_wr_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [BLK_W-1:0]  mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  vbc_state_t st;
  logic [VA_W-1:0] q_va;
  logic            q_wr;
  logic [7:0]      q_wd;
  logic [7:0]      r_byte;
  logic            r_miss;

  logic [VPN_W-1:0]  vpn;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic              t_hit;
  logic [PPN_W-1:0]  t_ppn;
  logic [CTAG_W-1:0] pa_tag;

  logic [1:0]             c_vld, c_dty, chv;
  logic [1:0][CTAG_W-1:0] c_tag;
  logic [1:0][LINE_W-1:0] c_data;
  logic                   c_lru, chit, cway, vic, vic_dirty;
  logic [7:0]             l_rbyte;
  logic [LINE_W-1:0]      l_merged;

  logic              a_wr_en, a_wr_way, a_wr_dirty, a_touch;
  logic [LINE_W-1:0] a_wr_data;
  logic              look;

  assign vpn    = q_va[VA_W-1:PAGE_W];
  assign idx    = q_va[OFF_W+IDX_W-1:OFF_W];
  assign off    = q_va[OFF_W-1:0];
  assign pa_tag = {t_ppn, q_va[PAGE_W-1:OFF_W+IDX_W]};
  assign look   = (st == ST_LOOK);

  vbc_tlb #(.SETS(TLB_SETS), .TAG_W(TLB_TAG_W), .PPN_W(PPN_W)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (vpn),
    .lk_touch (look),
    .lk_hit   (t_hit),
    .lk_ppn   (t_ppn),
    .wr_en    (tlb_wr_en),
    .wr_vpn   (tlb_wr_vpn),
    .wr_ppn   (tlb_wr_ppn)
  );

  vbc_cache_array #(.SETS(C_SETS), .TAG_W(CTAG_W), .LINE_W(LINE_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx),
    .o_vld     (c_vld),
    .o_dty     (c_dty),
    .o_tag     (c_tag),
    .o_data    (c_data),
    .o_lru     (c_lru),
    .wr_en     (a_wr_en),
    .wr_way    (a_wr_way),
    .wr_tag    (pa_tag),
    .wr_data   (a_wr_data),
    .wr_dirty  (a_wr_dirty),
    .touch_en  (a_touch),
    .touch_way (cway)
  );

  // Physical tag compare after the parallel set read and translation.
  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign chv[w] = c_vld[w] && (c_tag[w] == pa_tag);
  end
  assign chit      = |chv;
  assign cway      = chv[1];
  assign vic       = c_lru;
  assign vic_dirty = c_vld[vic] && c_dty[vic];

  vbc_lane #(.LINE_BYTES(LINE_BYTES)) u_lane (
    .line_in (c_data[cway]),
    .off     (off),
    .wbyte   (q_wd),
    .rbyte   (l_rbyte),
    .merged  (l_merged)
  );

  always_comb begin
    a_wr_en    = 1'b0;
    a_wr_way   = cway;
    a_wr_data  = l_merged;
    a_wr_dirty = 1'b1;
    if (look && t_hit && chit && q_wr) begin
      a_wr_en = 1'b1;
    end else if (st == ST_FWAIT && mem_rsp_valid) begin
      a_wr_en    = 1'b1;
      a_wr_way   = vic;
      a_wr_data  = mem_rsp_data;
      a_wr_dirty = 1'b0;
    end
  end
  assign a_touch = look && t_hit && chit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      q_va   <= '0;
      q_wr   <= 1'b0;
      q_wd   <= '0;
      r_byte <= '0;
      r_miss <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          q_va <= req_vaddr;
          q_wr <= req_write;
          q_wd <= req_wdata;
          st   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!t_hit) begin
            r_miss <= 1'b1;
            r_byte <= '0;
            st     <= ST_RESP;
          end else if (chit) begin
            r_miss <= 1'b0;
            r_byte <= q_wr ? 8'h00 : l_rbyte;
            st     <= ST_RESP;
          end else begin
            st <= vic_dirty ? ST_WB : ST_FREQ;
          end
        end
        ST_WB:    if (mem_req_ready) st <= ST_FREQ;
        ST_FREQ:  if (mem_req_ready) st <= ST_FWAIT;
        ST_FWAIT: if (mem_rsp_valid) st <= ST_LOOK;
        ST_RESP:  if (rsp_ready)     st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign rsp_valid     = (st == ST_RESP);
  assign rsp_rdata     = {{(DATA_W-8){1'b0}}, r_byte};
  assign rsp_tlb_miss  = r_miss;
  assign mem_req_valid = (st == ST_WB) || (st == ST_FREQ);
  assign mem_req_write = (st == ST_WB);
  assign mem_req_addr  = (st == ST_WB) ? {c_tag[vic], idx} : {pa_tag, idx};
  assign mem_req_wdata = c_data[vic];

  // R6
  cache_single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chv));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_tlb_miss));

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && mem_req_ready |=> mem_req_valid && !mem_req_write);

  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready && !rsp_valid);

  // R2
  tlb_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_tlb_miss |-> rsp_rdata == '0);
endmodule

// File: tb/test_vipt_byte_cache.sv
module test_vipt_byte_cache;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_tlb_miss;
  logic rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic tlb_wr_en = 1'b0;
  logic [17:0] tlb_wr_vpn = '0;
  logic [11:0] tlb_wr_ppn = '0;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b1;
  logic [22:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_byte_cache i_vipt_byte_cache (.*);

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, seq = 0, rd_seq = 0, wr_seq = 0, stall = 0;
  logic [22:0] last_rd = '0, last_wr = '0, pend_a = '0;
  logic [63:0] last_wd = '0;
  logic pend = 1'b0;
  logic [63:0] mem [logic [22:0]];
  logic [7:0]  shadow [logic [25:0]];
  logic [11:0] tlbmap [logic [17:0]];

  typedef struct { logic miss; logic [7:0] data; string tag; } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] dflt(logic [22:0] a);
    return 64'h0123456789ABCDEF ^ {a, 41'h0} ^ {41'h0, a};
  endfunction

  function automatic logic [63:0] mem_rd(logic [22:0] a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction

  function automatic logic [7:0] ref_byte(logic [25:0] pa);
    logic [63:0] l;
    if (shadow.exists(pa)) return shadow[pa];
    l = dflt(pa[25:3]);
    return l[63 - 8*pa[2:0] -: 8];
  endfunction

  function automatic logic [22:0] blk(logic [11:0] ppn, logic [13:0] po);
    logic [25:0] pa = {ppn, po};
    return pa[25:3];
  endfunction

  // Memory model: one read beat a cycle after each accepted read.
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_rd(pend_a);
      pend <= 1'b0;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      seq++;
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt++; wr_seq = seq; last_wr = mem_req_addr; last_wd = mem_req_wdata;
      end else begin
        pend <= 1'b1; pend_a <= mem_req_addr;
        rd_cnt++; rd_seq = seq; last_rd = mem_req_addr;
      end
    end
  end

  // Back-pressure pattern and response monitor.
  always @(negedge clk) begin
    exp_t e;
    stall++;
    mem_req_ready = (stall % 3) != 0;
    rsp_ready     = (stall % 4) != 1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected response", 1, 0);
      end else begin
        e = q.pop_front();
        chk(rsp_tlb_miss == e.miss, {e.tag, " miss flag"}, rsp_tlb_miss, e.miss);
        chk(rsp_rdata == {24'h0, e.data}, {e.tag, " data"}, rsp_rdata, e.data);
      end
    end
  end

  task automatic tlb_fill(logic [17:0] v, logic [11:0] p);
    @(negedge clk);
    tlb_wr_en = 1'b1; tlb_wr_vpn = v; tlb_wr_ppn = p;
    @(negedge clk);
    tlb_wr_en = 1'b0;
    tlbmap[v] = p;
  endtask

  task automatic do_req(bit wr, logic [31:0] va, logic [7:0] wd, string tag);
    exp_t e;
    logic [25:0] pa;
    e.tag = tag;
    if (!tlbmap.exists(va[31:14])) begin
      e.miss = 1'b1; e.data = 8'h00;
    end else begin
      pa = {tlbmap[va[31:14]], va[13:0]};
      e.miss = 1'b0;
      if (wr) begin shadow[pa] = wd; e.data = 8'h00; end
      else e.data = ref_byte(pa);
    end
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);

    // R2 untranslated page
    do_req(0, 32'h0000_1238, 8'h00, "R2 load no translation");
    do_req(1, 32'h0000_1230, 8'h77, "R2 store no translation");
    chk(rd_cnt == 0 && wr_cnt == 0, "R2 no memory traffic", rd_cnt + wr_cnt, 0);

    // R4 R6 clean load miss then hit
    tlb_fill(18'h00000, 12'h005);
    do_req(0, 32'h0000_1236, 8'h00, "R5 load miss offset 6");
    chk(rd_cnt == 1, "R6 one read", rd_cnt, 1);
    chk(last_rd == blk(12'h005, 14'h1236), "R4 read block address", last_rd, blk(12'h005, 14'h1236));
    do_req(0, 32'h0000_1230, 8'h00, "R5 hit offset 0");
    chk(rd_cnt == 1, "R6 hit no read", rd_cnt, 1);

    // R7 store hit
    do_req(1, 32'h0000_1237, 8'h5A, "R7 store hit");
    do_req(0, 32'h0000_1237, 8'h00, "R7 load stored byte");
    chk(rd_cnt == 1 && wr_cnt == 0, "R7 store hit no traffic", rd_cnt + wr_cnt, 1);

    // R11 alias page
    tlb_fill(18'h00001, 12'h005);
    do_req(0, 32'h0000_5237, 8'h00, "R11 alias read");
    chk(rd_cnt == 1, "R11 alias no read", rd_cnt, 1);

    // R9 fill into empty way, then dirty victim
    tlb_fill(18'h00002, 12'h0A0);
    do_req(0, 32'h0000_9230, 8'h00, "R9 second way fill");
    chk(rd_cnt == 2 && wr_cnt == 0, "R9 no writeback for empty way", wr_cnt, 0);
    tlb_fill(18'h00003, 12'h0B0);
    do_req(0, 32'h0000_D230, 8'h00, "R8 load with dirty victim");
    chk(wr_cnt == 1, "R8 one writeback", wr_cnt, 1);
    chk(last_wr == blk(12'h005, 14'h1230), "R8 writeback address", last_wr, blk(12'h005, 14'h1230));
    chk(last_wd[7:0] == 8'h5A, "R8 writeback holds merged byte at offset 7", last_wd[7:0], 8'h5A);
    chk(wr_seq < rd_seq, "R8 writeback before read", wr_seq, rd_seq);
    chk(rd_cnt == 3, "R8 read after writeback", rd_cnt, 3);
    do_req(0, 32'h0000_9233, 8'h00, "R9 recent way kept");
    chk(rd_cnt == 3, "R9 recent way hit", rd_cnt, 3);
    do_req(0, 32'h0000_1237, 8'h00, "R8 written-back byte refetched");
    chk(rd_cnt == 4 && wr_cnt == 1, "R9 clean victim no writeback", wr_cnt, 1);

    // R7 store miss allocates
    do_req(1, 32'h0000_1240, 8'hC3, "R7 store miss");
    chk(rd_cnt == 5, "R7 store miss fetches block", rd_cnt, 5);
    do_req(0, 32'h0000_1240, 8'h00, "R7 load after store miss");
    do_req(0, 32'h0000_1241, 8'h00, "R7 neighbour byte kept");
    chk(rd_cnt == 5, "R7 allocated line hits", rd_cnt, 5);

    // R3 refill replaces the matching way
    tlb_fill(18'h00004, 12'h0C0);
    do_req(0, 32'h0001_0008, 8'h00, "R3 second page in set 0");
    do_req(0, 32'h0000_1240, 8'h00, "R3 touch first page");
    tlb_fill(18'h00000, 12'h006);
    do_req(0, 32'h0001_0009, 8'h00, "R3 other entry kept");
    do_req(0, 32'h0000_1240, 8'h00, "R3 new frame used");
    chk(last_rd == blk(12'h006, 14'h1240), "R3 read uses new frame", last_rd, blk(12'h006, 14'h1240));
    do_req(0, 32'h0002_0000, 8'h00, "R2 unknown page in full set");

    finish_run();
  end
endmodule